// File: doc/BRIEF.md
# Parity-Checked Store Controller with Hardware Retry

This controller sits between a requester and a single-port store array. Every word it writes is stored with two check bits: one computed over the address alone and one over the address and data together. On every read the controller recomputes both bits and compares them with the returned ones. If the address bit disagrees, the fault is classed as an address fault. If only the combined bit disagrees, it is classed as a data fault.

A read that fails the check is issued again to the array, up to `MAX_RETRY` extra times. The requester only sees a longer delay, because `req_ready` stays low for the whole access. If a retry returns clean data, that data is delivered and a soft-error counter steps. If every attempt fails, the response carries an error flag, and the first such failure is latched as a sticky hard error together with its address and fault class. Byte parity guards the data entering and leaving the controller. A write whose incoming byte parity is wrong is refused.

The controller is built from the states IDLE, WRITE, ACCESS, CHECK and RESP. The transitions are:
- IDLE→WRITE: a write is accepted with good byte parity.
- IDLE→RESP: a write is accepted with bad byte parity and is refused.
- IDLE→ACCESS: a read is accepted.
- WRITE→RESP: the write completes.
- ACCESS→CHECK: the array is read.
- CHECK→RESP: the check passes, or the retries are exhausted.
- CHECK→ACCESS: the check fails and a retry is left.
- RESP→IDLE: the response is delivered.

Top module: `pstore_ctrl`

## Requirements
- R1: A write drives `mem_wchk[0]` = XOR of all address and data bits and `mem_wchk[1]` = XOR of all address bits. Bit 0 is the combined bit and bit 1 is the address-only bit.
- R2: A read whose check passes on the first attempt returns the stored data with `rsp_err`=0, and `rsp_valid` rises on the third rising edge after acceptance.
- R3: `rsp_rpar[i]` is the even parity (XOR) of `rsp_rdata[8i+7:8i]` on every response.
- R4: A write whose `req_wpar` differs from the byte parity of `req_wdata` does not touch the array. It is answered one edge after acceptance with `rsp_err`=1.
- R5: A read failing its check is reissued, at most `MAX_RETRY` times. Each retry adds two edges of latency, and `req_ready` stays 0 from acceptance to the response.
- R6: A read that passes on a retry returns the correct data with `rsp_err`=0, and `soft_cnt` increases by exactly one.
- R7: When all `MAX_RETRY`+1 attempts fail, the response has `rsp_err`=1 and `rsp_rdata`=0, and `hard_err` is set. `hard_err` and the `hard_addr` and `hard_kind` of the first hard failure hold until reset.
- R8: `hard_kind`=1 when the address-only bit mismatched on the final attempt. `hard_kind`=0 when only the combined bit mismatched.
- R9: After reset: `req_ready`=1, `rsp_valid`=0, `soft_cnt`=0 and `hard_err`=0.
- R10: Each accepted request gets exactly one response, with `rsp_valid` high for a single cycle. A good write answers two edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_wpar | input | DW/8 | Byte parity of write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DW | Read data |
| rsp_rpar | output | DW/8 | Byte parity of read data |
| rsp_err | output | 1 | Request failed |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| mem_wchk | output | 2 | Check bits to store |
| mem_rdata | input | DW | Array read data, one edge after a read |
| mem_rchk | input | 2 | Stored check bits, one edge after a read |
| soft_cnt | output | SCW | Reads recovered by retry |
| hard_err | output | 1 | Sticky unrecoverable-read flag |
| hard_addr | output | AW | Address of first hard failure |
| hard_kind | output | 1 | 1 = address fault, 0 = data fault |

## Verification
The bench builds the controller with `AW`=6, `DW`=16, `MAX_RETRY`=2 and `SCW`=8. The 16-bit data width exercises two independent byte-parity lanes. The 64-word array lets every address written be modelled exactly. With two retries, one, two and three consecutive corrupted returns cover both retry outcomes, and the bench can inject faults on the data, the combined bit and the address bit separately.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_ACCESS,
        ST_CHECK,
        ST_RESP
    } pst_state_e;
endpackage

// File: rtl/pstore_bytepar.sv
module pstore_bytepar #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   data,
    output logic [DW/8-1:0] par
);
    localparam int NB = DW / 8;
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign par[b] = ^data[8*b +: 8];
    end
endmodule

// File: rtl/pstore_chkgen.sv
module pstore_chkgen #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [1:0]    chk
);
    // bit 0: combined address+data, bit 1: address only
    assign chk[0] = ^{addr, data};
    assign chk[1] = ^addr;
endmodule

// File: rtl/pstore_chkeval.sv
module pstore_chkeval #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    input  logic [1:0]    rchk,
    output logic          bad,
    output logic          addr_fault
);
    logic [1:0] expect_chk;

    pstore_chkgen #(.AW(AW), .DW(DW)) u_regen (
        .addr (addr),
        .data (rdata),
        .chk  (expect_chk)
    );

    assign addr_fault = expect_chk[1] ^ rchk[1];
    assign bad        = addr_fault | (expect_chk[0] ^ rchk[0]);
endmodule

// File: rtl/pstore_ctrl.sv
module pstore_ctrl
    import pstore_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 16,
    parameter int MAX_RETRY = 2,
    parameter int SCW       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_wpar,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic [DW/8-1:0] rsp_rpar,
    output logic            rsp_err,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [1:0]      mem_wchk,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [1:0]      mem_rchk,
    output logic [SCW-1:0]  soft_cnt,
    output logic            hard_err,
    output logic [AW-1:0]   hard_addr,
    output logic            hard_kind
);
    localparam int NB = DW / 8;
    localparam int TW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
    localparam logic [TW-1:0]  TRY_LAST = TW'(MAX_RETRY);
    localparam logic [SCW-1:0] SOFT_MAX = {SCW{1'b1}};

    pst_state_e state_q, state_d;

    logic [AW-1:0]  a_q;
    logic [DW-1:0]  d_q;
    logic [TW-1:0]  tries_q;
    logic [DW-1:0]  rdata_q;
    logic           rerr_q;
    logic [SCW-1:0] soft_q;
    logic           hard_q;
    logic [AW-1:0]  haddr_q;
    logic           hkind_q;

    logic [NB-1:0]  in_par;
    logic           wpar_ok;
    logic           rd_bad;
    logic           rd_afault;
    logic           accept;

    pstore_bytepar #(.DW(DW)) u_inpar (
        .data (req_wdata),
        .par  (in_par)
    );

    pstore_chkgen #(.AW(AW), .DW(DW)) u_gen (
        .addr (a_q),
        .data (d_q),
        .chk  (mem_wchk)
    );

    pstore_chkeval #(.AW(AW), .DW(DW)) u_eval (
        .addr       (a_q),
        .rdata      (mem_rdata),
        .rchk       (mem_rchk),
        .bad        (rd_bad),
        .addr_fault (rd_afault)
    );

    pstore_bytepar #(.DW(DW)) u_outpar (
        .data (rdata_q),
        .par  (rsp_rpar)
    );

    assign wpar_ok = (in_par == req_wpar);
    assign accept  = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)   state_d = ST_ACCESS;
                    else if (wpar_ok) state_d = ST_WRITE;
                    else              state_d = ST_RESP;
                end
            end
            ST_WRITE:  state_d = ST_RESP;
            ST_ACCESS: state_d = ST_CHECK;
            ST_CHECK: begin
                if (rd_bad && (tries_q < TRY_LAST)) state_d = ST_ACCESS;
                else                                state_d = ST_RESP;
            end
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture, retry count and error record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            d_q     <= '0;
            tries_q <= '0;
            rdata_q <= '0;
            rerr_q  <= 1'b0;
            soft_q  <= '0;
            hard_q  <= 1'b0;
            haddr_q <= '0;
            hkind_q <= 1'b0;
        end else begin
            if (accept) begin
                a_q     <= req_addr;
                d_q     <= req_wdata;
                tries_q <= '0;
                rdata_q <= '0;
                rerr_q  <= req_write && !wpar_ok;
            end
            if (state_q == ST_CHECK) begin
                if (!rd_bad) begin
                    rdata_q <= mem_rdata;
                    rerr_q  <= 1'b0;
                    if ((tries_q != '0) && (soft_q != SOFT_MAX))
                        soft_q <= soft_q + SCW'(1);
                end else if (tries_q < TRY_LAST) begin
                    tries_q <= tries_q + TW'(1);
                end else begin
                    rdata_q <= '0;
                    rerr_q  <= 1'b1;
                    if (!hard_q) begin
                        hard_q  <= 1'b1;
                        haddr_q <= a_q;
                        hkind_q <= rd_afault;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_en    = (state_q == ST_ACCESS) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = a_q;
        mem_wdata = d_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
        rsp_err   = rerr_q;
        soft_cnt  = soft_q;
        hard_err  = hard_q;
        hard_addr = haddr_q;
        hard_kind = hkind_q;
    end
endmodule

// File: rtl/pstore_ctrl_chk.sv
module pstore_ctrl_chk #(
    parameter int AW  = 6,
    parameter int SCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           mem_en,
    input logic [SCW-1:0] soft_cnt,
    input logic           hard_err,
    input logic [AW-1:0]  hard_addr,
    input logic           hard_kind
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    a_r4_no_access_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_en);

    a_r7_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hard_err |=> hard_err);

    a_r7_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hard_err |=> ($stable(hard_addr) && $stable(hard_kind)));

    a_r6_soft_step: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_cnt != $past(soft_cnt)) |-> (soft_cnt == $past(soft_cnt) + SCW'(1)));
endmodule

bind pstore_ctrl pstore_ctrl_chk #(.AW(AW), .SCW(SCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_en    (mem_en),
    .soft_cnt  (soft_cnt),
    .hard_err  (hard_err),
    .hard_addr (hard_addr),
    .hard_kind (hard_kind)
);

// File: tb/pstore_ctrl_tb_top.sv
`timescale 1ns/1ps
module pstore_ctrl_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int MR = 2;
    localparam int SCW = 8;
    localparam int NB = DW / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_wpar = '0;
    logic req_ready, rsp_valid, rsp_err, mem_en, mem_we;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [NB-1:0] rsp_rpar;
    logic [AW-1:0] mem_addr, hard_addr;
    logic [1:0] mem_wchk, mem_rchk;
    logic [SCW-1:0] soft_cnt;
    logic hard_err, hard_kind;

    pstore_ctrl #(.AW(AW), .DW(DW), .MAX_RETRY(MR), .SCW(SCW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wpar(req_wpar),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_rpar(rsp_rpar), .rsp_err(rsp_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wchk(mem_wchk), .mem_rdata(mem_rdata), .mem_rchk(mem_rchk),
        .soft_cnt(soft_cnt), .hard_err(hard_err), .hard_addr(hard_addr), .hard_kind(hard_kind)
    );

    // behavioural array with fault injection on read returns
    logic [DW+1:0] ram [2**AW];
    logic [DW+1:0] rd_q = '0;
    logic [DW+1:0] inj_mask = '0;
    int inj_used = 0;
    int inj_limit = 0;
    assign mem_rdata = rd_q[DW-1:0];
    assign mem_rchk  = rd_q[DW+1:DW];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= {mem_wchk, mem_wdata};
            else begin
                rd_q <= ram[mem_addr] ^ ((inj_used < inj_limit) ? inj_mask : '0);
                if (inj_used < inj_limit) inj_used <= inj_used + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] bpar(input logic [DW-1:0] d);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
        return p;
    endfunction

    // reference state
    logic [DW-1:0] shadow [2**AW];
    int m_soft = 0;
    bit m_hard = 0, m_hkind = 0;
    logic [AW-1:0] m_haddr = '0;

    // op: 0 read, 1 write, 2 write with bad byte parity
    // fsel: 0 flip data bit 0, 1 flip address-only check bit, 2 flip combined check bit
    task automatic run(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int nflt, input int fsel, input bit experr);
        int cyc, explat, retr;
        bit rdy_seen;
        logic [DW-1:0] expd;
        @(negedge clk);
        inj_mask = (fsel == 0) ? (DW+2)'(1) : (fsel == 1) ? (DW+2)'(1) << (DW+1) : (DW+2)'(1) << DW;
        inj_limit = inj_used + nflt;
        req_valid = 1'b1;
        req_write = (op != 0);
        req_addr  = a;
        req_wdata = d;
        req_wpar  = bpar(d) ^ ((op == 2) ? NB'(1) : NB'(0));
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        rdy_seen = 1'b0;
        while (!rsp_valid && cyc < 40) begin
            if (req_ready) rdy_seen = 1'b1;
            if (mem_en && mem_we)
                chk(mem_wchk == {^a, ^{a, d}}, "R1", "stored check bits", int'(mem_wchk), int'({^a, ^{a, d}}));
            @(negedge clk);
            cyc++;
        end
        retr = (nflt > MR) ? MR : nflt;
        explat = (op == 0) ? 3 + 2 * retr : (op == 1) ? 2 : 1;
        chk(rsp_valid, "R10", "response arrives", 0, 1);
        chk(cyc == explat, (op == 0) ? ((retr > 0) ? "R5" : "R2") : ((op == 1) ? "R10" : "R4"),
            "latency", cyc, explat);
        chk(rsp_err == experr, (op == 2) ? "R4" : ((nflt > MR) ? "R7" : "R6"), "rsp_err", rsp_err, experr);
        chk(rsp_rpar == bpar(rsp_rdata), "R3", "response byte parity", rsp_rpar, bpar(rsp_rdata));
        if (op == 0) begin
            expd = (nflt > MR) ? '0 : shadow[a];
            chk(rsp_rdata == expd, (nflt == 0) ? "R2" : ((nflt > MR) ? "R7" : "R6"), "read data", rsp_rdata, expd);
            chk(!rdy_seen, "R5", "ready low while busy", rdy_seen, 0);
            if (nflt > 0 && nflt <= MR) m_soft++;
            if (nflt > MR && !m_hard) begin
                m_hard = 1; m_haddr = a; m_hkind = (fsel == 1);
            end
        end
        if (op == 1) shadow[a] = d;
        @(negedge clk);
        chk(!rsp_valid, "R10", "single-cycle response", rsp_valid, 0);
        chk(soft_cnt == SCW'(m_soft), "R6", "soft_cnt", soft_cnt, m_soft);
        chk(hard_err == m_hard, "R7", "hard_err", hard_err, m_hard);
        if (m_hard) begin
            chk(hard_addr == m_haddr, "R7", "hard_addr", hard_addr, m_haddr);
            chk(hard_kind == m_hkind, "R8", "hard_kind", hard_kind, m_hkind);
        end
    endtask

    // {op[1:0], addr[5:0], data[15:0], nflt[1:0], fsel[1:0], experr}
    localparam int NV = 11;
    localparam logic [28:0] VEC [NV] = '{
        {2'd1, 6'd5,  16'hA5A5, 2'd0, 2'd0, 1'b0},
        {2'd1, 6'd6,  16'h1234, 2'd0, 2'd0, 1'b0},
        {2'd1, 6'd63, 16'hFFFF, 2'd0, 2'd0, 1'b0},
        {2'd1, 6'd0,  16'h0001, 2'd0, 2'd0, 1'b0},
        {2'd0, 6'd5,  16'h0000, 2'd0, 2'd0, 1'b0},
        {2'd0, 6'd6,  16'h0000, 2'd1, 2'd0, 1'b0},
        {2'd0, 6'd63, 16'h0000, 2'd2, 2'd2, 1'b0},
        {2'd0, 6'd0,  16'h0000, 2'd1, 2'd1, 1'b0},
        {2'd2, 6'd5,  16'h0F0F, 2'd0, 2'd0, 1'b1},
        {2'd0, 6'd5,  16'h0000, 2'd0, 2'd0, 1'b0},
        {2'd0, 6'd6,  16'h0000, 2'd3, 2'd0, 1'b1}
    };

    task automatic reset_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_soft = 0; m_hard = 0; m_hkind = 0; m_haddr = '0;
        chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
        chk(soft_cnt == '0, "R9", "soft_cnt after reset", soft_cnt, 0);
        chk(hard_err == 1'b0, "R9", "hard_err after reset", hard_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) shadow[i] = '0;
        reset_check();
        for (int v = 0; v < NV; v++)
            run(int'(VEC[v][28:27]), VEC[v][26:21], VEC[v][20:5],
                int'(VEC[v][4:3]), int'(VEC[v][2:1]), VEC[v][0]);
        // second hard failure (address class) must not replace the first record: R7
        run(0, 6'd63, '0, 3, 1, 1'b1);
        // reset clears the record, then an address-class hard failure: R8
        reset_check();
        run(0, 6'd63, '0, 3, 1, 1'b1);
        // data fault on combined bit exhausting retries after reset keeps address record
        run(0, 6'd0, '0, 3, 2, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule